// File: doc/BRIEF.md
# Clock-Stop Serial Peripheral Master

This block is a full-duplex serial master that moves one word per request over a four-wire SPI-style link. Between transfers the serial clock is held low and the select line is high. A one-cycle start pulse latches the transmit word and the requested length. The block then pulls the active-low select down and clocks out the word most significant bit first. At the same time it captures the peripheral's reply.

Pacing comes from an external divider. That divider delivers a single-cycle `bitTick`, and every tick advances the link by one clock phase. The clock therefore stays high for one tick and low for one tick. The first rising edge comes one tick after the select falls. The select is released two ticks (one full clock period) after the last falling edge.

Data is launched on rising clock edges and the peripheral's data is sampled on falling edges. The output driver is released at the final falling edge. The received word then appears in parallel, together with a one-cycle done pulse. The word length can be set from 8 to 32 bits. Values outside that range are clamped to the nearest limit.

Top module: `clkStopSpiMaster`

## Requirements
- R1: After reset, and while idle, `sclk` is 0, `csN` is 1, `sdoEn` is 0, `sdo` is 0 and `done` is 0.
- R2: A `start` pulse seen while idle makes `csN` go low on the next clock edge. On that same edge `sdoEn` goes to 1 and `sdo` shows the most significant bit of the effective word.
- R3: `sclk` changes only on clock edges where `bitTick` is 1. Each change takes exactly one tick. The first rising edge comes exactly one tick after `csN` falls. Every high phase and every low phase lasts one tick.
- R4: The number of `sclk` rising edges in a transfer equals the effective length. The effective length is `wordLen` clamped to the range 8 to 32: values below 8 act as 8 and values above 32 act as 32.
- R5: Transmit bits leave most significant first. Bit i of the sequence (i = 0 for `txWord[len-1]`) is on `sdo` from rising edge i until rising edge i+1. The first bit is already valid from the fall of `csN`.
- R6: `sdi` is sampled at each falling edge of `sclk`. At completion, `rxWord[len-1:0]` holds the sampled bits with the first sampled bit most significant, and the bits above `len` are 0. `rxWord` then holds its value until the next transfer completes.
- R7: `sdoEn` goes to 0 at the clock edge that makes the last falling edge of `sclk`. `sdo` is 0 whenever `sdoEn` is 0.
- R8: `csN` returns high exactly two ticks after the last falling edge. `done` is 1 for exactly one cycle, in the same cycle that `csN` first reads high.
- R9: A `start` pulse that arrives while a transfer is in progress is ignored. The running transfer keeps its word, length and timing, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle phase advance from the external divider |
| start | input | 1 | One-cycle transfer request |
| txWord | input | 32 | Word to send, right-justified |
| wordLen | input | 6 | Requested length in bits (clamped to 8..32) |
| sdi | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock, idles low |
| csN | output | 1 | Active-low peripheral select |
| sdo | output | 1 | Serial data to the peripheral |
| sdoEn | output | 1 | Output driver enable for `sdo` (0 = high impedance) |
| rxWord | output | 32 | Received word, right-justified |
| done | output | 1 | One-cycle completion pulse |

## Verification
Transfers are run at lengths 8, 13, 16 and 32. The transmit words are alternating patterns, the all-ones word and the all-zeros word, and each transfer uses a reply pattern that differs from the transmitted word. The alternating words expose a reversed bit order or a misaligned shift. The all-ones and all-zeros words expose stuck bits. The odd length of 13 shows whether the word is aligned correctly to its most significant bit. Because the reply differs from the transmitted word, a receive path that loops back the output is caught.

Lengths of 3 and 45 check the clamping at both limits. A second start pulse in the middle of a transfer checks that a busy request is ignored. Tick-counted measurements of the lead, each phase and the trail check the frame timing.

// File: rtl/clkStopSpiPkg.sv
package clkStopSpiPkg;

  typedef struct packed {
    logic load;      // capture word, clear receive shifter
    logic shiftTx;   // advance transmit shifter (on a rising sclk edge)
    logic sampleRx;  // shift in sdi (on a falling sclk edge)
    logic publish;   // copy receive shifter to rxWord
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL
  } seqState_t;

endpackage

// File: rtl/clkStopSpiControl.sv
module clkStopSpiControl
  import clkStopSpiPkg::*;
#(
  parameter int MIN_BITS = 8,
  parameter int MAX_BITS = 32,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             start,
  input  logic [LEN_W-1:0] wordLen,
  output logic [LEN_W-1:0] effLen,
  output dpStrobe_t        strobe,
  output logic             sclk,
  output logic             csN,
  output logic             sdoEn,
  output logic             done
);

  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_BITS);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  seqState_t        state;
  logic [LEN_W-1:0] bitsLeft;
  logic             trailHalf;

  // Clamp the requested length into the supported range.
  always_comb begin
    if (wordLen < LEN_MIN)      effLen = LEN_MIN;
    else if (wordLen > LEN_MAX) effLen = LEN_MAX;
    else                        effLen = wordLen;
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && start;
    strobe.shiftTx  = (state == ST_LOW) && bitTick;
    strobe.sampleRx = (state == ST_HIGH) && bitTick;
    strobe.publish  = (state == ST_TRAIL) && bitTick && trailHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitsLeft  <= '0;
      trailHalf <= 1'b0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
      sdoEn     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LEAD;
            bitsLeft <= effLen;
            csN      <= 1'b0;
            sdoEn    <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (bitTick) begin
            state <= ST_HIGH;
            sclk  <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (bitTick) begin
            sclk     <= 1'b0;
            bitsLeft <= bitsLeft - LEN_ONE;
            if (bitsLeft == LEN_ONE) begin
              state     <= ST_TRAIL;
              sdoEn     <= 1'b0;
              trailHalf <= 1'b0;
            end else begin
              state <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (bitTick) begin
            state <= ST_HIGH;
            sclk  <= 1'b1;
          end
        end
        ST_TRAIL: begin
          if (bitTick) begin
            if (trailHalf) begin
              state <= ST_IDLE;
              csN   <= 1'b1;
              done  <= 1'b1;
            end
            trailHalf <= ~trailHalf;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkStopSpiDatapath.sv
module clkStopSpiDatapath
  import clkStopSpiPkg::*;
#(
  parameter int MAX_BITS = 32,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [LEN_W-1:0]    effLen,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic                sdi,
  input  logic                sdoEn,
  output logic                sdo,
  output logic [MAX_BITS-1:0] rxWord
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);

  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;
  logic [LEN_W-1:0]    alignAmt;

  assign alignAmt = LEN_MAX - effLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= txWord << alignAmt;
        rxShift <= '0;
      end else begin
        if (strobe.shiftTx)  txShift <= {txShift[MAX_BITS-2:0], 1'b0};
        if (strobe.sampleRx) rxShift <= {rxShift[MAX_BITS-2:0], sdi};
      end
      if (strobe.publish) rxWord <= rxShift;
    end
  end

  assign sdo = txShift[MAX_BITS-1] & sdoEn;

endmodule

// File: rtl/clkStopSpiMaster.sv
module clkStopSpiMaster
  import clkStopSpiPkg::*;
#(
  parameter int MIN_BITS = 8,
  parameter int MAX_BITS = 32,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic                start,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                sdi,
  output logic                sclk,
  output logic                csN,
  output logic                sdo,
  output logic                sdoEn,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                done
);

  dpStrobe_t        strobe;
  logic [LEN_W-1:0] effLen;

  clkStopSpiControl #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .start(start),
    .wordLen(wordLen), .effLen(effLen), .strobe(strobe),
    .sclk(sclk), .csN(csN), .sdoEn(sdoEn), .done(done)
  );

  clkStopSpiDatapath #(.MAX_BITS(MAX_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .effLen(effLen),
    .txWord(txWord), .sdi(sdi), .sdoEn(sdoEn), .sdo(sdo), .rxWord(rxWord)
  );

endmodule

// File: rtl/clkStopSpiChecker.sv
module clkStopSpiChecker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic start,
  input logic sclk,
  input logic csN,
  input logic sdo,
  input logic sdoEn,
  input logic done
);

  assert_clk_in_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  assert_tick_paced_R3: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(sclk));

  assert_drive_in_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !csN);

  assert_quiet_when_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdo);

  assert_select_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(start));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_with_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN));

endmodule

bind clkStopSpiMaster clkStopSpiChecker u_chk (.*);

// File: tb/clkStopSpiMaster_test.sv
module clkStopSpiMaster_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0;
  logic        start = 1'b0;
  logic [31:0] txWord = '0;
  logic [5:0]  wordLen = 6'd8;
  logic        sdi = 1'b0;
  logic        sclk, csN, sdo, sdoEn, done;
  logic [31:0] rxWord;

  int checks = 0;
  int errors = 0;

  clkStopSpiMaster uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .start(start),
    .txWord(txWord), .wordLen(wordLen), .sdi(sdi), .sclk(sclk),
    .csN(csN), .sdo(sdo), .sdoEn(sdoEn), .rxWord(rxWord), .done(done)
  );

  always #4 clk = ~clk;

  int tickCount = 0;
  always @(posedge clk) if (bitTick) tickCount <= tickCount + 1;

  // Divider stand-in: one tick every third cycle.
  initial begin
    forever begin
      @(negedge clk) bitTick = 1'b1;
      @(negedge clk) bitTick = 1'b0;
      @(negedge clk) bitTick = 1'b0;
    end
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected transfer, set by the scenario tasks.
  logic [31:0] expTx = '0;
  logic [31:0] expPat = '0;
  int          expLen = 8;

  // Monitor state.
  logic prevSclk = 1'b0;
  logic prevCs = 1'b1;
  int   riseCnt = 0;
  int   doneCount = 0;
  int   csFallTick = 0;
  int   riseTick = 0;
  int   fallTick = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !csN) begin
        csFallTick = tickCount;
        riseCnt = 0;
        check("R2", "sdoEn at select fall", sdoEn, 1);
        check("R2", "MSB at select fall", sdo, expTx[expLen-1]);
      end
      if (!prevSclk && sclk) begin
        if (riseCnt == 0)
          check("R3", "lead ticks", tickCount - csFallTick, 1);
        else
          check("R3", "low phase ticks", tickCount - fallTick, 1);
        riseTick = tickCount;
        if (riseCnt < expLen) begin
          check("R5", "sdo bit after rise", sdo, expTx[expLen-1-riseCnt]);
          sdi = expPat[expLen-1-riseCnt];
        end
        riseCnt++;
      end
      if (prevSclk && !sclk) begin
        check("R3", "high phase ticks", tickCount - riseTick, 1);
        fallTick = tickCount;
        check("R7", "sdoEn after fall", sdoEn, (riseCnt < expLen) ? 1 : 0);
      end
      if (!prevCs && csN) begin
        check("R8", "trail ticks", tickCount - fallTick, 2);
        check("R8", "done at select rise", done, 1);
        check("R4", "rising edge count", riseCnt, expLen);
        check("R6", "received word", rxWord,
              expPat & ((expLen == 32) ? 32'hFFFF_FFFF : ((32'd1 << expLen) - 1)));
      end
      if (done) doneCount++;
      prevSclk = sclk;
      prevCs = csN;
    end
  end

  task automatic pulseStart(input logic [31:0] w, input logic [5:0] len);
    @(negedge clk);
    txWord = w;
    wordLen = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (csN && !start && doneCount > 0) break;
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, "idle sclk", sclk, 0);
    check(req, "idle csN", csN, 1);
    check(req, "idle sdoEn", sdoEn, 0);
    check(req, "idle sdo", sdo, 0);
    check(req, "idle done", done, 0);
  endtask

  task automatic runXfer(input logic [31:0] w, input logic [31:0] pat,
                         input logic [5:0] len, input int effL, input string req);
    expTx = w;
    expPat = pat;
    expLen = effL;
    doneCount = 0;
    pulseStart(w, len);
    waitIdle();
    check(req, "done pulses", doneCount, 1);
    repeat (8) @(negedge clk);
    check("R6", "rxWord held", rxWord,
          pat & ((effL == 32) ? 32'hFFFF_FFFF : ((32'd1 << effL) - 1)));
    checkIdle("R1");
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkIdle("R1");
    check("R1", "reset rxWord", rxWord, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkIdle("R1");
  endtask

  task automatic testBusyStart();
    expTx = 32'h0000_C3A5;
    expPat = 32'h0000_5A3C;
    expLen = 16;
    doneCount = 0;
    pulseStart(32'h0000_C3A5, 6'd16);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (riseCnt >= 3) break;
    end
    // R9: second request mid-transfer with a different word and length
    pulseStart(32'hFFFF_FFFF, 6'd32);
    txWord = 32'h0;
    waitIdle();
    check("R9", "single done", doneCount, 1);
    repeat (20) @(negedge clk);
    check("R9", "no follow-up transfer csN", csN, 1);
    check("R9", "no follow-up done", doneCount, 1);
  endtask

  initial begin
    testReset();
    runXfer(32'h0000_00A5, 32'h0000_003C, 6'd8,  8,  "R4");
    runXfer(32'h0000_1234, 32'h0000_EDCB, 6'd16, 16, "R5");
    runXfer(32'h0000_1A5B, 32'h0000_0C3D, 6'd13, 13, "R5");
    runXfer(32'hAAAA_5555, 32'h3C3C_C3C3, 6'd32, 32, "R6");
    runXfer(32'hFFFF_FFFF, 32'h0000_0000, 6'd32, 32, "R5");
    runXfer(32'h0000_0000, 32'hFFFF_FFFF, 6'd32, 32, "R6");
    runXfer(32'h1234_5678, 32'h0000_0099, 6'd3,  8,  "R4");
    runXfer(32'h8765_4321, 32'h0F0F_1E1E, 6'd45, 32, "R4");
    testBusyStart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule